// File: doc/BRIEF.md
# Misaligned Access Splitting Sequencer

This block sits between the address generator of a load/store pipeline and a level-one data cache built from two line banks: one for even line numbers, one for odd. It takes a load or store of 1, 2, 4 or 8 bytes at any byte address. When the bytes all fall inside one 64-byte line, it issues a single cache access. When they run past the end of a line, it splits the access into a low fragment, which covers the tail of the first line, and a high fragment, which covers the head of the next line. The two fragments go to opposite banks in the same cycle.

The first line's physical frame arrives with the request. If the high fragment stays inside the same 4 kB frame, its line address is the first line's index plus one. If it falls into the next page, the block first asks a translation port for the frame of the following virtual page. The high fragment then targets line 0 of the returned frame. A fault on that lookup ends the access with an error, and no cache access is issued, so a faulting store writes nothing.

For loads, the two returned lines are joined and shifted into one right-aligned, zero-extended result. For stores, the data and byte enables are placed on the correct lanes of each fragment. Only one access is in flight at a time. Completion is a single-cycle done pulse.

Top module: `misalign_splitter`

## Requirements
- R1: The size code `req_size` selects 2^code bytes (0=1, 1=2, 2=4, 3=8). An access whose line offset (`req_vaddr[5:0]`) plus byte count is at most 64 issues exactly one cache request. It goes to bank `req_vaddr[6]` with line address `{req_pfn, req_vaddr[11:6]}`, and no translation request is made.
- R2: An access whose offset plus byte count exceeds 64, with line index `req_vaddr[11:6]` below 63, issues two cache requests in the same cycle. The high one goes to the other bank with line address `{req_pfn, req_vaddr[11:6]+1}`, and no translation request is made.
- R3: A line-crossing access with line index 63 first raises `xl_req_valid` for one cycle with `xl_req_vpn = req_vaddr[31:12]+1`, with no cache request in that cycle. After a non-faulting response, the high fragment targets line address `{xl_rsp_pfn, 6'd0}` in bank 0.
- R4: For a load, byte k of `done_rdata` equals the memory byte at virtual address `req_vaddr+k` for k below the byte count. Bytes of the first line come before bytes of the second, and all bytes at or above the byte count are zero.
- R5: A load at line offset 0 returns lanes 0 up to byte count minus 1 of the addressed line, unshifted.
- R6: A store enables lanes offset up to min(63, offset+count-1) of the low fragment, and lanes 0 up to offset+count-65 of the high fragment. Store byte k lands on the lane holding address `req_vaddr+k`, and the total number of enabled lanes equals the byte count.
- R7: The two fragment responses may arrive in either order and at any latency. `done_valid` rises only after every issued fragment has answered.
- R8: `req_ready` is low from the cycle after acceptance up to and including the done cycle. Each accepted request produces exactly one single-cycle `done_valid` pulse, after which `req_ready` is high again.
- R9: A translation response with `xl_rsp_fault` set gives `done_err`=1 and `done_rdata`=0, and no cache request is issued for that access.
- R10: During reset `req_ready` is 1, while `done_valid`, `xl_req_valid` and both `bank_req_valid` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Size code, byte count 2^code |
| req_vaddr | input | 32 | Virtual byte address |
| req_pfn | input | 20 | Physical frame of the first byte's page |
| req_wdata | input | 64 | Store data, right-aligned |
| xl_req_valid | output | 1 | Translation lookup for the following page |
| xl_req_vpn | output | 20 | Virtual page number to translate |
| xl_rsp_valid | input | 1 | Translation response |
| xl_rsp_fault | input | 1 | Translation failed |
| xl_rsp_pfn | input | 20 | Returned physical frame |
| bank_req_valid | output | 2 | Per-bank cache request (bit 0 even, bit 1 odd) |
| bank_req_store | output | 1 | Cache requests are writes |
| bank_req_line | output | 2 x 26 | Per-bank physical line address |
| bank_req_be | output | 2 x 64 | Per-bank lane write enables |
| bank_req_wdata | output | 2 x 512 | Per-bank lane write data |
| bank_rsp_valid | input | 2 | Per-bank completion |
| bank_rsp_rdata | input | 2 x 512 | Per-bank returned line |
| done_valid | output | 1 | Access finished (one cycle) |
| done_err | output | 1 | Access aborted by translation fault |
| done_rdata | output | 64 | Merged, zero-extended load data |

## Verification
The assertions assume the surroundings behave as a cache and TLB would. Each bank answers once for each request it received, and only after that request. A translation response comes only while a lookup is outstanding. `req_valid` is offered only while `req_ready` is high. The bench's responder follows these rules: it answers only requests it has observed, with independent random latencies of one to four cycles per bank, so the fragments return in both orders. Its request stream is random but weighted toward line and page ends, with directed cases at offsets 0, 56, 57, 63 and address 0xFFF, and with faults injected only on page-crossing lookups.

// File: rtl/misalign_pkg.sv
package misalign_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DISPATCH,
      ST_XWAIT,
      ST_FIRE,
      ST_WAIT,
      ST_RESP
   } seq_state_e;

endpackage

// File: rtl/misalign_decode.sv
module misalign_decode #(
   parameter int PFN_W      = 20,
   parameter int LINE_BYTES = 64,
   parameter int PAGE_BYTES = 4096,
   parameter int SZ_W       = 2,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int PG_W      = $clog2(PAGE_BYTES),
   localparam int IDX_W     = PG_W - OFF_W,
   localparam int LA_W      = PFN_W + IDX_W
) (
   input  logic [PG_W-1:0]  pg_off,
   input  logic [SZ_W-1:0]  size,
   input  logic [PFN_W-1:0] pfn_lo,
   input  logic [PFN_W-1:0] pfn_hi,
   output logic [OFF_W-1:0] off,
   output logic [OFF_W:0]   nbytes,
   output logic             cross_line,
   output logic             cross_page,
   output logic             lo_bank,
   output logic [LA_W-1:0]  lo_line,
   output logic [LA_W-1:0]  hi_line
);

   logic [IDX_W-1:0] idx;
   logic [OFF_W:0]   end_pos;

   assign off     = pg_off[OFF_W-1:0];
   assign idx     = pg_off[PG_W-1:OFF_W];
   assign nbytes  = (OFF_W+1)'(1) << size;
   assign end_pos = {1'b0, off} + nbytes;

   // one past the last byte lies beyond the line end
   assign cross_line = end_pos > (OFF_W+1)'(LINE_BYTES);
   assign cross_page = cross_line && (&idx);
   assign lo_bank    = idx[0];

   assign lo_line = {pfn_lo, idx};
   assign hi_line = cross_page ? {pfn_hi, IDX_W'(0)} : {pfn_lo, idx + IDX_W'(1)};

endmodule

// File: rtl/misalign_store_align.sv
module misalign_store_align #(
   parameter int LINE_BYTES = 64,
   parameter int DATA_BYTES = 8,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LINE_W    = LINE_BYTES * 8,
   localparam int DATA_W    = DATA_BYTES * 8
) (
   input  logic [OFF_W-1:0]      off,
   input  logic [OFF_W:0]        nbytes,
   input  logic [DATA_W-1:0]     wdata,
   output logic [LINE_W-1:0]     lo_data,
   output logic [LINE_W-1:0]     hi_data,
   output logic [LINE_BYTES-1:0] lo_be,
   output logic [LINE_BYTES-1:0] hi_be
);

   logic [DATA_BYTES-1:0]   size_mask;
   logic [DATA_W-1:0]       wdata_m;
   logic [2*LINE_W-1:0]     wide_data;
   logic [2*LINE_BYTES-1:0] wide_be;

   for (genvar i = 0; i < DATA_BYTES; i++) begin : g_byte
      assign size_mask[i]        = (OFF_W+1)'(i) < nbytes;
      assign wdata_m[i*8 +: 8]   = size_mask[i] ? wdata[i*8 +: 8] : 8'h00;
   end

   // place the access on a two-line lane space, then cut it at the line edge
   assign wide_data = {{(2*LINE_W-DATA_W){1'b0}}, wdata_m} << {off, 3'b000};
   assign wide_be   = {{(2*LINE_BYTES-DATA_BYTES){1'b0}}, size_mask} << off;

   assign lo_data = wide_data[LINE_W-1:0];
   assign hi_data = wide_data[2*LINE_W-1:LINE_W];
   assign lo_be   = wide_be[LINE_BYTES-1:0];
   assign hi_be   = wide_be[2*LINE_BYTES-1:LINE_BYTES];

endmodule

// File: rtl/misalign_load_merge.sv
module misalign_load_merge #(
   parameter int LINE_BYTES = 64,
   parameter int DATA_BYTES = 8,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LINE_W    = LINE_BYTES * 8,
   localparam int DATA_W    = DATA_BYTES * 8
) (
   input  logic [OFF_W-1:0]  off,
   input  logic [OFF_W:0]    nbytes,
   input  logic              use_hi,
   input  logic [LINE_W-1:0] lo_line,
   input  logic [LINE_W-1:0] hi_line,
   output logic [DATA_W-1:0] rdata
);

   logic [2*LINE_W-1:0] wide;
   logic [DATA_W-1:0]   raw;

   // funnel shift over both lines: no complementary shift amount exists,
   // so a zero offset simply selects the first line's low lanes
   assign wide = {(use_hi ? hi_line : {LINE_W{1'b0}}), lo_line} >> {off, 3'b000};
   assign raw  = wide[DATA_W-1:0];

   for (genvar i = 0; i < DATA_BYTES; i++) begin : g_zext
      assign rdata[i*8 +: 8] = ((OFF_W+1)'(i) < nbytes) ? raw[i*8 +: 8] : 8'h00;
   end

endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter #(
   parameter int VA_W        = 32,
   parameter int PFN_W       = 20,
   parameter int LINE_BYTES  = 64,
   parameter int PAGE_BYTES  = 4096,
   parameter int DATA_BYTES  = 8,
   localparam int OFF_W      = $clog2(LINE_BYTES),
   localparam int PG_W       = $clog2(PAGE_BYTES),
   localparam int IDX_W      = PG_W - OFF_W,
   localparam int LA_W       = PFN_W + IDX_W,
   localparam int VPN_W      = VA_W - PG_W,
   localparam int LINE_W     = LINE_BYTES * 8,
   localparam int DATA_W     = DATA_BYTES * 8,
   localparam int SZ_W       = $clog2($clog2(DATA_BYTES) + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic                        req_store,
   input  logic [SZ_W-1:0]             req_size,
   input  logic [VA_W-1:0]             req_vaddr,
   input  logic [PFN_W-1:0]            req_pfn,
   input  logic [DATA_W-1:0]           req_wdata,
   output logic                        xl_req_valid,
   output logic [VPN_W-1:0]            xl_req_vpn,
   input  logic                        xl_rsp_valid,
   input  logic                        xl_rsp_fault,
   input  logic [PFN_W-1:0]            xl_rsp_pfn,
   output logic [1:0]                  bank_req_valid,
   output logic                        bank_req_store,
   output logic [1:0][LA_W-1:0]        bank_req_line,
   output logic [1:0][LINE_BYTES-1:0]  bank_req_be,
   output logic [1:0][LINE_W-1:0]      bank_req_wdata,
   input  logic [1:0]                  bank_rsp_valid,
   input  logic [1:0][LINE_W-1:0]      bank_rsp_rdata,
   output logic                        done_valid,
   output logic                        done_err,
   output logic [DATA_W-1:0]           done_rdata
);
   import misalign_pkg::*;

   initial begin
      assert ((1 << OFF_W) == LINE_BYTES) else $fatal(1, "line size must be a power of two");
      assert ((1 << PG_W) == PAGE_BYTES) else $fatal(1, "page size must be a power of two");
      assert (PAGE_BYTES >= 2 * LINE_BYTES) else $fatal(1, "page must hold at least two lines");
      assert (DATA_BYTES <= LINE_BYTES && (1 << $clog2(DATA_BYTES)) == DATA_BYTES)
         else $fatal(1, "access width must be a power of two no wider than a line");
      assert (VA_W > PG_W) else $fatal(1, "address narrower than a page");
   end

   seq_state_e        state_q;
   logic              st_store_q;
   logic [SZ_W-1:0]   st_size_q;
   logic [VA_W-1:0]   st_va_q;
   logic [PFN_W-1:0]  pfn_lo_q, pfn_hi_q;
   logic [DATA_W-1:0] wdata_q;
   logic              got_lo_q, got_hi_q, err_q;
   logic [LINE_W-1:0] lo_buf_q, hi_buf_q;

   logic [OFF_W-1:0]      off;
   logic [OFF_W:0]        nbytes;
   logic                  cross_line, cross_page, lo_bank;
   logic [LA_W-1:0]       lo_line, hi_line;
   logic [LINE_W-1:0]     lo_data, hi_data;
   logic [LINE_BYTES-1:0] lo_be, hi_be;
   logic [DATA_W-1:0]     merged;
   logic                  issue, lo_hit, hi_hit, lo_ok, hi_ok;

   misalign_decode #(
      .PFN_W(PFN_W), .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES), .SZ_W(SZ_W)
   ) u_decode (
      .pg_off(st_va_q[PG_W-1:0]), .size(st_size_q), .pfn_lo(pfn_lo_q), .pfn_hi(pfn_hi_q),
      .off(off), .nbytes(nbytes), .cross_line(cross_line), .cross_page(cross_page),
      .lo_bank(lo_bank), .lo_line(lo_line), .hi_line(hi_line)
   );

   misalign_store_align #(
      .LINE_BYTES(LINE_BYTES), .DATA_BYTES(DATA_BYTES)
   ) u_store (
      .off(off), .nbytes(nbytes), .wdata(wdata_q),
      .lo_data(lo_data), .hi_data(hi_data), .lo_be(lo_be), .hi_be(hi_be)
   );

   misalign_load_merge #(
      .LINE_BYTES(LINE_BYTES), .DATA_BYTES(DATA_BYTES)
   ) u_merge (
      .off(off), .nbytes(nbytes), .use_hi(cross_line),
      .lo_line(lo_buf_q), .hi_line(hi_buf_q), .rdata(merged)
   );

   assign issue  = (state_q == ST_DISPATCH && !cross_page) || (state_q == ST_FIRE);
   assign lo_hit = bank_rsp_valid[lo_bank];
   assign hi_hit = bank_rsp_valid[~lo_bank] && cross_line;
   assign lo_ok  = got_lo_q || lo_hit;
   assign hi_ok  = !cross_line || got_hi_q || hi_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         st_store_q <= 1'b0;
         st_size_q  <= '0;
         st_va_q    <= '0;
         pfn_lo_q   <= '0;
         pfn_hi_q   <= '0;
         wdata_q    <= '0;
         got_lo_q   <= 1'b0;
         got_hi_q   <= 1'b0;
         err_q      <= 1'b0;
         lo_buf_q   <= '0;
         hi_buf_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               st_store_q <= req_store;
               st_size_q  <= req_size;
               st_va_q    <= req_vaddr;
               pfn_lo_q   <= req_pfn;
               wdata_q    <= req_wdata;
               got_lo_q   <= 1'b0;
               got_hi_q   <= 1'b0;
               err_q      <= 1'b0;
               state_q    <= ST_DISPATCH;
            end
            ST_DISPATCH: state_q <= cross_page ? ST_XWAIT : ST_WAIT;
            ST_XWAIT: if (xl_rsp_valid) begin
               if (xl_rsp_fault) begin
                  err_q   <= 1'b1;
                  state_q <= ST_RESP;
               end else begin
                  pfn_hi_q <= xl_rsp_pfn;
                  state_q  <= ST_FIRE;
               end
            end
            ST_FIRE: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (lo_hit) begin
                  got_lo_q <= 1'b1;
                  lo_buf_q <= bank_rsp_rdata[lo_bank];
               end
               if (hi_hit) begin
                  got_hi_q <= 1'b1;
                  hi_buf_q <= bank_rsp_rdata[~lo_bank];
               end
               if (lo_ok && hi_ok) state_q <= ST_RESP;
            end
            ST_RESP: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready      = (state_q == ST_IDLE);
   assign xl_req_valid   = (state_q == ST_DISPATCH) && cross_page;
   assign xl_req_vpn     = st_va_q[VA_W-1:PG_W] + VPN_W'(1);
   assign bank_req_store = st_store_q;
   assign done_valid     = (state_q == ST_RESP);
   assign done_err       = err_q;
   assign done_rdata     = (done_valid && !err_q && !st_store_q) ? merged : '0;

   logic [1:0][LINE_BYTES-1:0] be_live;

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic is_lo;
      assign is_lo             = (lo_bank == 1'(b));
      assign bank_req_valid[b] = issue && (is_lo || cross_line);
      assign bank_req_line[b]  = is_lo ? lo_line : hi_line;
      assign bank_req_be[b]    = st_store_q ? (is_lo ? lo_be : hi_be) : '0;
      assign bank_req_wdata[b] = is_lo ? lo_data : hi_data;
      assign be_live[b]        = bank_req_valid[b] ? bank_req_be[b] : '0;

      // each bank only ever sees lines of its own parity (R1, R2)
      p_bank_parity_r1: assert property (@(posedge clk) disable iff (!rst_n)
         bank_req_valid[b] |-> (bank_req_line[b][0] == 1'(b)));
   end

   p_xlate_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xl_req_valid |-> (bank_req_valid == 2'b00));

   p_fault_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_XWAIT && xl_rsp_valid && xl_rsp_fault)
         |=> (done_valid && done_err && bank_req_valid == 2'b00));

   p_store_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_req_store && (|bank_req_valid)) |-> ($countones(be_live) == int'(nbytes)));

   p_done_after_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_err) |-> (got_lo_q && (got_hi_q || !cross_line)));

   p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> (!done_valid && req_ready));

endmodule

// File: tb/misalign_splitter_tb.sv
module misalign_splitter_tb;

   localparam int LA_W   = 26;
   localparam int LINE_W = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic                   req_valid = 1'b0, req_ready, req_store = 1'b0;
   logic [1:0]             req_size = '0;
   logic [31:0]            req_vaddr = '0;
   logic [19:0]            req_pfn = '0;
   logic [63:0]            req_wdata = '0;
   logic                   xl_req_valid;
   logic [19:0]            xl_req_vpn;
   logic                   xl_rsp_valid = 1'b0, xl_rsp_fault = 1'b0;
   logic [19:0]            xl_rsp_pfn = '0;
   logic [1:0]             bank_req_valid;
   logic                   bank_req_store;
   logic [1:0][LA_W-1:0]   bank_req_line;
   logic [1:0][63:0]       bank_req_be;
   logic [1:0][LINE_W-1:0] bank_req_wdata;
   logic [1:0]             bank_rsp_valid = '0;
   logic [1:0][LINE_W-1:0] bank_rsp_rdata = '0;
   logic                   done_valid, done_err;
   logic [63:0]            done_rdata;

   misalign_splitter u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
      .req_size(req_size), .req_vaddr(req_vaddr), .req_pfn(req_pfn), .req_wdata(req_wdata),
      .xl_req_valid(xl_req_valid), .xl_req_vpn(xl_req_vpn),
      .xl_rsp_valid(xl_rsp_valid), .xl_rsp_fault(xl_rsp_fault), .xl_rsp_pfn(xl_rsp_pfn),
      .bank_req_valid(bank_req_valid), .bank_req_store(bank_req_store),
      .bank_req_line(bank_req_line), .bank_req_be(bank_req_be), .bank_req_wdata(bank_req_wdata),
      .bank_rsp_valid(bank_rsp_valid), .bank_rsp_rdata(bank_rsp_rdata),
      .done_valid(done_valid), .done_err(done_err), .done_rdata(done_rdata)
   );

   int n_vec = 0;
   int n_bad = 0;
   logic [7:0] exp_byte [logic [31:0]];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] mem_byte(input logic [31:0] pa);
      logic [31:0] h;
      h = pa * 32'h9E3779B1;
      return h[31:24] ^ h[15:8];
   endfunction

   function automatic logic [LINE_W-1:0] line_of(input logic [LA_W-1:0] la);
      logic [LINE_W-1:0] d;
      for (int i = 0; i < 64; i++) d[i*8 +: 8] = mem_byte({la, i[5:0]});
      return d;
   endfunction

   function automatic logic [19:0] tlb_pfn(input logic [19:0] vpn);
      return vpn ^ 20'h5A3C1;
   endfunction

   function automatic logic [31:0] phys_of(input logic [31:0] va, input logic [19:0] pfn, input int k);
      logic [31:0] vk;
      vk = va + 32'(k);
      return (vk[31:12] == va[31:12]) ? {pfn, vk[11:0]} : {tlb_pfn(vk[31:12]), vk[11:0]};
   endfunction

   task automatic run_access(input logic st, input logic [1:0] sz, input logic [31:0] va,
                             input logic [19:0] pfn, input logic [63:0] wd, input logic flt);
      int nb, cyc, busy_bad, nreq, wr_cnt, wr_bad, store_flag_bad;
      int bw [2];
      bit cl, cp, xl_seen, vpn_ok;
      logic [LA_W-1:0] la_seen [2];
      bit seen [2];
      logic [63:0] exp_rd;
      logic [LA_W-1:0] exp_lo, exp_hi;
      string ltag, dtag;

      nb = 1 << sz;
      cl = (int'(va[5:0]) + nb) > 64;
      cp = cl && (va[11:6] == 6'h3F);
      exp_lo = {pfn, va[11:6]};
      exp_hi = cp ? {tlb_pfn(va[31:12] + 20'd1), 6'd0} : {pfn, va[11:6] + 6'd1};
      ltag = cp ? "R3" : (cl ? "R2" : "R1");
      exp_byte.delete();
      exp_rd = '0;
      for (int k = 0; k < nb; k++) begin
         exp_byte[phys_of(va, pfn, k)] = wd[k*8 +: 8];
         exp_rd[k*8 +: 8] = mem_byte(phys_of(va, pfn, k));
      end
      bw[0] = 0; bw[1] = 0; seen[0] = 0; seen[1] = 0;
      la_seen[0] = '0; la_seen[1] = '0;
      cyc = 0; busy_bad = 0; nreq = 0; wr_cnt = 0; wr_bad = 0; store_flag_bad = 0;
      xl_seen = 0; vpn_ok = 0;

      @(negedge clk);
      chk(req_ready === 1'b1, "R8", "ready while idle", {63'd0, req_ready}, 64'd1);
      req_valid = 1'b1; req_store = st; req_size = sz; req_vaddr = va;
      req_pfn = pfn; req_wdata = wd; xl_rsp_fault = flt;
      @(negedge clk);
      req_valid = 1'b0;
      forever begin
         xl_rsp_valid = 1'b0;
         bank_rsp_valid = 2'b00;
         if (done_valid === 1'b1 || cyc > 200) break;
         if (req_ready !== 1'b0) busy_bad++;
         if (xl_req_valid === 1'b1) begin
            xl_seen = 1;
            vpn_ok = (xl_req_vpn == va[31:12] + 20'd1);
            xl_rsp_pfn = tlb_pfn(xl_req_vpn);
            bw[0] = bw[0]; // lookup latency held in cyc-based countdown below
            for (int d = 0; d < int'($urandom % 3); d++) begin
               @(negedge clk); cyc++;
               if (req_ready !== 1'b0) busy_bad++;
            end
            @(negedge clk); cyc++;
            xl_rsp_valid = 1'b1;
            @(negedge clk); cyc++;
            continue;
         end
         for (int b = 0; b < 2; b++) begin
            if (bank_req_valid[b] === 1'b1) begin
               nreq++;
               seen[b] = 1;
               la_seen[b] = bank_req_line[b];
               if (bank_req_store !== st) store_flag_bad++;
               if (st) begin
                  for (int l = 0; l < 64; l++) begin
                     if (bank_req_be[b][l]) begin
                        logic [31:0] pa;
                        pa = {bank_req_line[b], l[5:0]};
                        wr_cnt++;
                        if (!exp_byte.exists(pa)) wr_bad++;
                        else if (exp_byte[pa] != bank_req_wdata[b][l*8 +: 8]) wr_bad++;
                     end
                  end
               end
               bw[b] = 1 + int'($urandom % 4);
            end else if (bw[b] > 0) begin
               bw[b]--;
               if (bw[b] == 0) begin
                  bank_rsp_valid[b] = 1'b1;
                  bank_rsp_rdata[b] = line_of(la_seen[b]);
               end
            end
         end
         @(negedge clk); cyc++;
      end

      if (cyc > 200) begin
         chk(1'b0, "R8", "access never completed", 64'(cyc), 64'd200);
         return;
      end
      chk(busy_bad == 0, "R8", "ready low while busy", 64'(busy_bad), 64'd0);
      chk(bw[0] == 0 && bw[1] == 0, "R7", "done before all fragments returned",
          {32'(bw[1]), 32'(bw[0])}, 64'd0);
      chk(xl_seen == cp, ltag, "translation request issued", {63'd0, xl_seen}, {63'd0, cp});
      if (cp) chk(vpn_ok, "R3", "next-page vpn", 64'(xl_req_vpn), 64'(va[31:12] + 20'd1));
      chk(done_err === (cp && flt), "R9", "done_err", {63'd0, done_err}, {63'd0, cp && flt});
      if (cp && flt) begin
         chk(nreq == 0, "R9", "cache requests after fault", 64'(nreq), 64'd0);
         chk(done_rdata === 64'd0, "R9", "rdata after fault", done_rdata, 64'd0);
      end else begin
         chk(nreq == (cl ? 2 : 1) && store_flag_bad == 0, ltag, "fragment count",
             64'(nreq), cl ? 64'd2 : 64'd1);
         chk(seen[va[6]] && la_seen[va[6]] == exp_lo, ltag, "low fragment line",
             64'(la_seen[va[6]]), 64'(exp_lo));
         if (cl) chk(seen[~va[6]] && la_seen[~va[6]] == exp_hi, ltag, "high fragment line",
                     64'(la_seen[~va[6]]), 64'(exp_hi));
         if (st) begin
            chk(wr_bad == 0 && wr_cnt == nb, "R6", "store lanes",
                {32'(wr_bad), 32'(wr_cnt)}, 64'(nb));
         end else begin
            dtag = (va[5:0] == 6'd0) ? "R5" : "R4";
            chk(done_rdata === exp_rd, dtag, "load data", done_rdata, exp_rd);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h00C0FFEE);
      repeat (2) @(negedge clk);
      // R10: state while reset is held
      chk(req_ready === 1'b1 && done_valid === 1'b0 && xl_req_valid === 1'b0 &&
          bank_req_valid === 2'b00, "R10", "reset outputs",
          {59'd0, req_ready, done_valid, xl_req_valid, bank_req_valid}, 64'h10);
      rst_n = 1'b1;

      // directed corners
      run_access(1'b0, 2'd3, 32'h0001_2340, 20'h00AB1, 64'h0, 1'b0); // R5 offset 0, 8 bytes
      run_access(1'b0, 2'd1, 32'h0007_7FC0, 20'h00123, 64'h0, 1'b0); // R5 offset 0, 2 bytes
      run_access(1'b0, 2'd3, 32'h0003_4578, 20'h0F00D, 64'h0, 1'b0); // offset 56, fits exactly
      run_access(1'b0, 2'd3, 32'h0003_4579, 20'h0F00D, 64'h0, 1'b0); // offset 57, R2 cross
      run_access(1'b0, 2'd1, 32'h0003_40BF, 20'h0F00D, 64'h0, 1'b0); // offset 63, 2 bytes
      run_access(1'b0, 2'd0, 32'h0003_40BF, 20'h0F00D, 64'h0, 1'b0); // 1 byte at 63
      run_access(1'b0, 2'd3, 32'h0005_5FFF, 20'h12345, 64'h0, 1'b0); // R3 page cross load
      run_access(1'b1, 2'd3, 32'h0005_5FFA, 20'h12345, 64'h1122_3344_5566_7788, 1'b0); // R3 store
      run_access(1'b1, 2'd2, 32'h0009_1FFE, 20'h0BEEF, 64'hDEAD_BEEF_CAFE_F00D, 1'b1); // R9 store
      run_access(1'b0, 2'd3, 32'h0009_1FF9, 20'h0BEEF, 64'h0, 1'b1);                  // R9 load
      run_access(1'b1, 2'd3, 32'h0000_0A7D, 20'h00777, 64'h0102_0304_0506_0708, 1'b0); // R6 split
      run_access(1'b1, 2'd1, 32'h0000_0A40, 20'h00777, 64'hFFFF_FFFF_FFFF_A55A, 1'b0); // R6 no split

      // constrained random, weighted to line and page ends
      for (int n = 0; n < 400; n++) begin
         logic [31:0] va;
         logic [1:0] sz;
         logic st, flt;
         int pick;
         va = $urandom;
         sz = 2'($urandom % 4);
         st = 1'($urandom % 2);
         pick = int'($urandom % 3);
         if (pick == 0) va[11:0] = 12'hFF8 + 12'($urandom % 8);
         else if (pick == 1) va[5:0] = 6'd56 + 6'($urandom % 8);
         flt = (($urandom % 4) == 0);
         run_access(st, sz, va, 20'($urandom), {$urandom, $urandom}, flt);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule